// File: doc/BRIEF.md
# Segmented Oscillator Tuning Word Encoder

This block turns a 13-bit oscillator tuning word into the switch controls of a segmented resistance network. The word is split into four fields. The three upper fields (coarse, medium, fine) each pass through their own binary-to-thermometer converter. The four lowest bits feed a first-order sigma-delta modulator. Its overflow pulse adds one extra fine step on the clocks where it fires. Over time this gives sixteen times the average resolution of the fine step alone.

The block runs on a dither clock. A new tuning word takes effect only on a clock edge where the load strobe is high. The modulator's accumulator keeps running across loads. Only reset clears it.

Top module: `dco_tune_encoder`

## Requirements
- R1: Field positions in `tune_word` are: coarse = bits [12:11], medium = bits [10:8], fine = bits [7:4], dither = bits [3:0].
- R2: `coarse_th` is 3 lines wide. For a coarse value N it holds exactly N ones, filled from bit 0 upward, with all higher lines zero.
- R3: `medium_th` is 7 lines wide. For a medium value N it holds exactly N ones, filled from bit 0 upward.
- R4: `fine_th` is 15 lines wide. It holds min(fine + `dither_o`, 15) ones, filled from bit 0 upward. When fine is 15, a dither pulse adds nothing, and it never changes `medium_th` or `coarse_th`.
- R5: `tune_word` is captured only at a rising clock edge where `load` is 1. The thermometer outputs reflect the captured word from that edge on. With `load` at 0, changes on `tune_word` have no effect on any output.
- R6: A 4-bit accumulator adds the captured dither value D on every clock edge, modulo 16. `dither_o` is 1 exactly when the accumulator value plus D reaches 16 or more. It is evaluated from the current accumulator and the captured D.
- R7: Over any 16 consecutive clocks with a constant captured D, `dither_o` is 1 on exactly D of them.
- R8: The accumulator residue is kept across loads. Reset (`rst_n` low at a clock edge, synchronous) clears both the captured word and the accumulator. After reset, loading D = 1 yields the first `dither_o` pulse on the 16th cycle after the loading edge.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dither clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Capture strobe for `tune_word` |
| tune_word | input | 13 | Tuning word: coarse, medium, fine, dither fields |
| coarse_th | output | 3 | Coarse thermometer lines |
| medium_th | output | 7 | Medium thermometer lines |
| fine_th | output | 15 | Fine thermometer lines including the dither step |
| dither_o | output | 1 | Sigma-delta overflow pulse |

## Verification
A word loaded at a rising edge shows up on the coarse and medium lines in the same cycle, right after that edge, with no further register delay. `dither_o`, and through it `fine_th`, depend on the accumulator, which moves on every edge. Their expected values therefore change every cycle. The bench keeps its own accumulator model, advanced once per rising edge using the dither value that was captured before that edge. It compares every output at the following falling edge. Pulse counts are taken over windows of exactly 16 falling-edge samples that follow a load.

// File: rtl/dco_tune_pkg.sv
// Package: default field widths of the tuning word encoder.
// Assumes the word is laid out coarse | medium | fine | dither, MSB first.
package dco_tune_pkg;
    localparam int COARSE_BITS = 2;
    localparam int MEDIUM_BITS = 3;
    localparam int FINE_BITS   = 4;
    localparam int DITHER_BITS = 4;
endpackage

// File: rtl/bin2therm.sv
// Binary-to-thermometer converter.
// Line i is high when the binary input is greater than i, so value N
// lights lines 0..N-1. Purely combinational; assumes BITS >= 1.
module bin2therm #(
    parameter int BITS = 3
) (
    input  logic [BITS-1:0]        bin_i,
    output logic [(1<<BITS)-2:0]   therm_o
);
    localparam int LINES = (1 << BITS) - 1;

    // one comparator per output line
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign therm_o[i] = (bin_i > BITS'(i));
    end

    // lines must form an unbroken run of ones starting at bit 0
    always_comb begin
        // R2
        therm_shape_chk: assert (((therm_o + LINES'(1)) & therm_o) == '0);
    end
endmodule

// File: rtl/sd_dither.sv
// First-order sigma-delta modulator: an accumulator adds the dither
// value each clock; the adder carry-out is the dither pulse.
// Assumes d_i only changes between clock edges (it comes from a register).
module sd_dither #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic         carry_o
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;

    // adder with carry-out
    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, d_i};
        carry_o = sum[W];
    end

    // accumulator register, keeps residue until reset
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= sum[W-1:0];
    end

    // window monitor: cycles and pulses counted while d_i stays constant
    localparam int SPAN = 1 << W;
    logic [W:0]   win_q;
    logic [W:0]   pulses_q;
    logic [W-1:0] d_last_q;

    // restart the window when d_i changes or after a full span
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q    <= '0;
            pulses_q <= '0;
            d_last_q <= '0;
        end else begin
            d_last_q <= d_i;
            if (d_i != d_last_q || win_q == (W+1)'(SPAN)) begin
                win_q    <= (W+1)'(1);
                pulses_q <= (W+1)'(carry_o);
            end else begin
                win_q    <= win_q + (W+1)'(1);
                pulses_q <= pulses_q + (W+1)'(carry_o);
            end
        end
    end

    // R7
    dither_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q == (W+1)'(SPAN)) |-> (pulses_q == {1'b0, d_last_q}));
endmodule

// File: rtl/dco_tune_encoder.sv
// Segmented tuning word encoder.
// Captures a tuning word on load, expands coarse/medium/fine fields to
// thermometer lines, and dithers the fine field by one step using a
// sigma-delta carry (saturating at full scale). Synchronous active-low reset.
module dco_tune_encoder
    import dco_tune_pkg::*;
#(
    parameter int C_BITS = COARSE_BITS,
    parameter int M_BITS = MEDIUM_BITS,
    parameter int F_BITS = FINE_BITS,
    parameter int D_BITS = DITHER_BITS
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                load,
    input  logic [C_BITS+M_BITS+F_BITS+D_BITS-1:0] tune_word,
    output logic [(1<<C_BITS)-2:0]              coarse_th,
    output logic [(1<<M_BITS)-2:0]              medium_th,
    output logic [(1<<F_BITS)-2:0]              fine_th,
    output logic                                dither_o
);
    localparam int WORD_W = C_BITS + M_BITS + F_BITS + D_BITS;
    localparam int F_LO   = D_BITS;
    localparam int M_LO   = F_LO + F_BITS;
    localparam int C_LO   = M_LO + M_BITS;

    logic [WORD_W-1:0] word_q;
    logic [C_BITS-1:0] coarse_q;
    logic [M_BITS-1:0] medium_q;
    logic [F_BITS-1:0] fine_q;
    logic [D_BITS-1:0] dith_q;
    logic [F_BITS:0]   fine_sum;
    logic [F_BITS-1:0] fine_eff;

    // capture register for the tuning word
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= tune_word;
    end

    // field split
    assign coarse_q = word_q[C_LO +: C_BITS];
    assign medium_q = word_q[M_LO +: M_BITS];
    assign fine_q   = word_q[F_LO +: F_BITS];
    assign dith_q   = word_q[0 +: D_BITS];

    sd_dither #(.W(D_BITS)) u_sd (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_i     (dith_q),
        .carry_o (dither_o)
    );

    // add the dither step to the fine field, clamping at full scale
    always_comb begin
        fine_sum = {1'b0, fine_q} + {{F_BITS{1'b0}}, dither_o};
        fine_eff = fine_sum[F_BITS] ? '1 : fine_sum[F_BITS-1:0];
    end

    bin2therm #(.BITS(C_BITS)) u_coarse (.bin_i(coarse_q), .therm_o(coarse_th));
    bin2therm #(.BITS(M_BITS)) u_medium (.bin_i(medium_q), .therm_o(medium_th));
    bin2therm #(.BITS(F_BITS)) u_fine   (.bin_i(fine_eff), .therm_o(fine_th));

    // R4
    fine_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_q == '1) |-> (fine_th == '1));

    // R4
    fine_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dither_o && fine_q != '1) |-> ($countones(fine_th) == int'(fine_q) + 1));

    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(coarse_th) && $stable(medium_th) && $stable(fine_q)));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (coarse_th == '0 && medium_th == '0 && fine_q == '0 && dith_q == '0));
endmodule

// File: tb/tb_dco_tune_encoder.sv
module tb_dco_tune_encoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        load;
    logic [12:0] tune_word;
    logic [2:0]  coarse_th;
    logic [6:0]  medium_th;
    logic [14:0] fine_th;
    logic        dither_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // bench-side model state
    logic [12:0] word_m = '0;
    int          acc_m  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dco_tune_encoder dut (
        .clk(clk), .rst_n(rst_n), .load(load), .tune_word(tune_word),
        .coarse_th(coarse_th), .medium_th(medium_th),
        .fine_th(fine_th), .dither_o(dither_o)
    );

    typedef struct packed {
        logic [12:0] w;
        logic [2:0]  c;
        logic [6:0]  m;
        logic [14:0] f;
    } vec_t;

    // dither field zero in every row, so no carry occurs
    localparam vec_t VECS [6] = '{
        '{13'h0000, 3'b000, 7'h00, 15'h0000},
        '{13'h1FF0, 3'b111, 7'h7F, 15'h7FFF},
        '{13'h0A30, 3'b001, 7'h03, 15'h0007},
        '{13'h1590, 3'b011, 7'h1F, 15'h01FF},
        '{13'h0710, 3'b000, 7'h7F, 15'h0001},
        '{13'h1880, 3'b111, 7'h00, 15'h00FF}
    };

    function automatic logic [14:0] therm(int n);
        return 15'((32'd1 << n) - 1);
    endfunction

    function automatic bit exp_carry();
        return (acc_m + int'(word_m[3:0])) >= 16;
    endfunction

    function automatic logic [14:0] exp_fine();
        int v = int'(word_m[7:4]) + int'(exp_carry());
        if (v > 15) v = 15;
        return therm(v);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: model follows the registers, then sample at the falling edge
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            acc_m  = 0;
            word_m = '0;
        end else begin
            acc_m = (acc_m + int'(word_m[3:0])) % 16;
            if (load) word_m = tune_word;
        end
        @(negedge clk);
    endtask

    task automatic load_word(logic [12:0] w);
        tune_word = w;
        load = 1'b1;
        step();
        load = 1'b0;
    endtask

    task automatic check_dyn(string req);
        check(req, 32'(dither_o), 32'(exp_carry()));
        check(req, 32'(fine_th), 32'(exp_fine()));
    endtask

    // run 16 cycles and return number of dither pulses, checking every cycle
    task automatic window16(string req, output int pulses);
        pulses = 0;
        for (int k = 0; k < 16; k++) begin
            check_dyn(req);
            if (dither_o) pulses++;
            step();
        end
    endtask

    initial begin
        int p;
        rst_n = 1'b0; load = 1'b0; tune_word = '0;
        @(negedge clk);
        step(); step();
        rst_n = 1'b1;
        // R9 reset state
        check("R9", 32'(coarse_th), 0);
        check("R9", 32'(medium_th), 0);
        check("R9", 32'(fine_th), 0);
        check("R9", 32'(dither_o), 0);

        // R1 R2 R3 R4 table walk
        for (int i = 0; i < 6; i++) begin
            load_word(VECS[i].w);
            check("R2", 32'(coarse_th), 32'(VECS[i].c));
            check("R3", 32'(medium_th), 32'(VECS[i].m));
            check("R4", 32'(fine_th), 32'(VECS[i].f));
            check("R1", 32'(dither_o), 0);
        end

        // R5 word ignored without load
        tune_word = 13'h0000;
        step(); step(); step();
        check("R5", 32'(coarse_th), 32'h7);
        check("R5", 32'(medium_th), 32'h00);
        check("R5", 32'(fine_th), 32'h00FF);
        check("R5", 32'(dither_o), 0);

        // R6 R7 pulse counts for several dither values
        load_word(13'h0A35);
        window16("R6", p);
        check("R7", 32'(p), 5);
        load_word(13'h0A3F);
        window16("R6", p);
        check("R7", 32'(p), 15);
        load_word(13'h0A30);
        window16("R6", p);
        check("R7", 32'(p), 0);

        // R4 saturation at fine = 15 with dither 8
        load_word(13'h1FF8);
        p = 0;
        for (int k = 0; k < 16; k++) begin
            check("R4", 32'(fine_th), 32'h7FFF);
            check("R4", 32'(medium_th), 32'h7F);
            check("R4", 32'(coarse_th), 32'h7);
            if (dither_o) p++;
            step();
        end
        check("R7", 32'(p), 8);

        // R8 residue kept across loads
        load_word(13'h0033);
        for (int k = 0; k < 5; k++) begin check_dyn("R8"); step(); end
        load_word(13'h0047);
        for (int k = 0; k < 20; k++) begin check_dyn("R8"); step(); end

        // R8 reset clears accumulator: D=1 gives first pulse on cycle 16
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        check("R9", 32'(coarse_th | medium_th | fine_th | dither_o), 0);
        load_word(13'h0001);
        p = 0;
        for (int k = 1; k < 16; k++) begin
            if (dither_o) p++;
            step();
        end
        check("R8", 32'(p), 0);
        check("R8", 32'(dither_o), 1);
        check("R8", 32'(fine_th), 32'h0001);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule